// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This unit takes a logical address, given as a 16-bit segment selector and a 32-bit offset, and returns the linear address that the paging stage translates next. The selector picks one 64-bit segment descriptor. The descriptor comes from one of two tables in memory. The system table is shared by every process, and its byte address is held in a base register loaded from a dedicated write port. The per-process table has no address port of its own. A load request names a descriptor in the system table, and the unit copies that descriptor's base and limit into its local-table register.

Each request goes through a valid/ready handshake and gets exactly one response pulse. A translation checks the selector first. If the selector passes, the unit fetches the descriptor as two 32-bit words through a read port with variable latency. It then checks the present bit and the segment limit and adds the segment base to the offset. Any violation produces a fault response in place of an address.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0, and no per-process table is installed.
- R2: The selector layout is: bits [15:3] hold the index, bit 2 selects the table (0 = system table, 1 = per-process table), and bits [1:0] are ignored. Changing bits [1:0] never changes the result.
- R3: A translation reads descriptor word 0 at `table_base + index*8` and then word 1 at that address + 4. On success it returns `rsp_fault`=0 and `rsp_lin` = base + offset, modulo 2^32.
- R4: Descriptor word 0 is the 32-bit segment base. In word 1, bits [19:0] are the byte limit and bit 31 is the present flag. An offset equal to the limit is accepted, and an offset greater than the limit faults.
- R5: A descriptor whose present flag is 0 faults after both words are read. Every fault response carries `rsp_lin` = 0.
- R6: A translation that uses the system table with index 0 faults without any memory read. Its `rsp_valid` pulse comes in the cycle right after acceptance.
- R7: A load request (`req_load`=1) reads the named system-table descriptor. On success it installs that descriptor's base and limit as the per-process table, and returns `rsp_lin` = that base. Later per-process selectors are read from the installed table.
- R8: A per-process selector faults without any memory read in two cases: no table has been installed, or `index*8+7` exceeds the installed table's byte limit. Index 0 is legal in the per-process table.
- R9: A load request faults, and leaves the installed per-process table unchanged, in three cases: its selector has table bit 1, its index is 0, or the named descriptor is not present. Faults for table bit 1 or index 0 issue no memory read.
- R10: `req_ready` is 1 only while idle, so one request is in flight at a time. `rsp_valid` is a single-cycle pulse. `mem_rd_en` is a single-cycle pulse per word and is never high while idle. A request issues at most two reads.
- R11: Each read waits for its `mem_rd_valid`, for any latency of one cycle or more, and the result does not depend on that latency.
- R12: A write on `gtab_wr_en` replaces the system-table base that requests accepted afterwards use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtab_wr_en | input | 1 | Load the system-table base register |
| gtab_wr_base | input | 32 | New system-table byte address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when both are high |
| req_load | input | 1 | 0 = translate, 1 = install per-process table |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Request faulted |
| rsp_lin | output | 32 | Linear address, or installed base for a load, or 0 on a fault |
| mem_rd_en | output | 1 | Read command pulse |
| mem_rd_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rd_data | input | 32 | Returned word |
| mem_rd_valid | input | 1 | Returned word is valid |

## Verification
The bound checker watches the handshake on every cycle. It checks that a response never coincides with readiness, that response and read pulses last one cycle, that no read is issued while idle, that an accepted request drops readiness, that faults carry a zero address, and that a null system selector is answered at once. The directed scenarios are the only way to show the arithmetic and the table behaviour. These include base plus offset with wraparound, the two word addresses, the exact limit boundary, the present flag, and which table a selector reaches. They also include that a failed load keeps the earlier per-process table, that the result does not change with memory latency, and that ignored selector bits have no effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      XS_IDLE   = 3'd0,
      XS_ISSUE0 = 3'd1,
      XS_WAIT0  = 3'd2,
      XS_ISSUE1 = 3'd3,
      XS_WAIT1  = 3'd4,
      XS_RESP   = 3'd5
   } xlate_state_t;

   localparam logic KIND_XLATE = 1'b0;
   localparam logic KIND_LOAD  = 1'b1;

   localparam logic TBL_SYSTEM  = 1'b0;
   localparam logic TBL_PROCESS = 1'b1;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SEL_W   = 16,
   parameter int IDX_W   = 13,
   parameter int LIMIT_W = 20
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic               kind,
   input  logic [ADDR_W-1:0]  sys_base,
   input  logic [ADDR_W-1:0]  proc_base,
   input  logic [LIMIT_W-1:0] proc_limit,
   input  logic               proc_ok,
   output logic [ADDR_W-1:0]  entry_addr,
   output logic               pre_fault
);
   localparam int RSV_W   = SEL_W - IDX_W - 1;
   localparam int TI_BIT  = SEL_W - IDX_W - 1;
   localparam int ENT_SH  = 3;

   logic [IDX_W-1:0]  idx;
   logic              tbl;
   logic [ADDR_W-1:0] ent_off;
   logic [ADDR_W-1:0] ent_last;
   logic [ADDR_W-1:0] lim_ext;
   logic              idx_zero;

   assign idx = sel[SEL_W-1 -: IDX_W];
   assign tbl = sel[TI_BIT];

   generate
      if (RSV_W > 0) begin : g_rsv
         logic [RSV_W-1:0] rsv_unused;
         assign rsv_unused = sel[RSV_W-1:0];
      end
      if (LIMIT_W < ADDR_W) begin : g_lim_ext
         assign lim_ext = {{(ADDR_W-LIMIT_W){1'b0}}, proc_limit};
      end else begin : g_lim_full
         assign lim_ext = proc_limit[ADDR_W-1:0];
      end
   endgenerate

   assign ent_off  = {{(ADDR_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
   assign ent_last = ent_off + ADDR_W'(7);
   assign idx_zero = (idx == '0);

   always_comb begin
      if (kind == KIND_XLATE && tbl == TBL_PROCESS)
         entry_addr = proc_base + ent_off;
      else
         entry_addr = sys_base + ent_off;
   end

   always_comb begin
      if (kind == KIND_LOAD)
         pre_fault = (tbl == TBL_PROCESS) || idx_zero;
      else if (tbl == TBL_SYSTEM)
         pre_fault = idx_zero;
      else
         pre_fault = !proc_ok || (ent_last > lim_ext);
   end

endmodule

// File: rtl/seg_desc_eval.sv
module seg_desc_eval
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 20,
   parameter int PRES_BIT = 31
) (
   input  logic               kind,
   input  logic [ADDR_W-1:0]  word0,
   input  logic [ADDR_W-1:0]  word1,
   input  logic [ADDR_W-1:0]  offset,
   output logic [ADDR_W-1:0]  seg_base,
   output logic [LIMIT_W-1:0] seg_limit,
   output logic               fault,
   output logic [ADDR_W-1:0]  result
);
   localparam int GAP_W = PRES_BIT - LIMIT_W;

   logic              present;
   logic [ADDR_W-1:0] lim_ext;
   logic              over;

   assign seg_base  = word0;
   assign seg_limit = word1[LIMIT_W-1:0];
   assign present   = word1[PRES_BIT];

   generate
      if (GAP_W > 0) begin : g_gap
         logic [GAP_W-1:0] gap_unused;
         assign gap_unused = word1[PRES_BIT-1:LIMIT_W];
      end
      if (PRES_BIT < ADDR_W-1) begin : g_top
         logic [ADDR_W-2-PRES_BIT:0] top_unused;
         assign top_unused = word1[ADDR_W-1:PRES_BIT+1];
      end
      if (LIMIT_W < ADDR_W) begin : g_ext
         assign lim_ext = {{(ADDR_W-LIMIT_W){1'b0}}, seg_limit};
      end else begin : g_full
         assign lim_ext = seg_limit[ADDR_W-1:0];
      end
   endgenerate

   assign over  = (kind == KIND_XLATE) && (offset > lim_ext);
   assign fault = !present || over;

   always_comb begin
      if (fault)
         result = '0;
      else if (kind == KIND_LOAD)
         result = seg_base;
      else
         result = seg_base + offset;
   end

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
   import seg_xlate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic pre_fault,
   input  logic rd_valid,
   output logic ready,
   output logic rd_en,
   output logic rd_second,
   output logic cap_word0,
   output logic cap_word1,
   output logic rsp_pulse
);
   xlate_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         XS_IDLE:   if (accept) st_d = pre_fault ? XS_RESP : XS_ISSUE0;
         XS_ISSUE0: st_d = XS_WAIT0;
         XS_WAIT0:  if (rd_valid) st_d = XS_ISSUE1;
         XS_ISSUE1: st_d = XS_WAIT1;
         XS_WAIT1:  if (rd_valid) st_d = XS_RESP;
         XS_RESP:   st_d = XS_IDLE;
         default:   st_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= XS_IDLE;
      else        st_q <= st_d;
   end

   assign ready     = (st_q == XS_IDLE);
   assign rd_en     = (st_q == XS_ISSUE0) || (st_q == XS_ISSUE1);
   assign rd_second = (st_q == XS_ISSUE1);
   assign cap_word0 = (st_q == XS_WAIT0) && rd_valid;
   assign cap_word1 = (st_q == XS_WAIT1) && rd_valid;
   assign rsp_pulse = (st_q == XS_RESP);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SEL_W    = 16,
   parameter int IDX_W    = 13,
   parameter int LIMIT_W  = 20,
   parameter int PRES_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gtab_wr_en,
   input  logic [ADDR_W-1:0] gtab_wr_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_load,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [ADDR_W-1:0] req_off,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_lin,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [ADDR_W-1:0] mem_rd_data,
   input  logic              mem_rd_valid
);
   localparam int WORD_BYTES = 4;

   generate
      if (SEL_W < IDX_W + 1) begin : g_bad_sel
         $error("selector too narrow for index and table bit");
      end
      if (ADDR_W < IDX_W + 4) begin : g_bad_addr
         $error("address too narrow for table entries");
      end
      if (PRES_BIT < LIMIT_W || PRES_BIT >= ADDR_W) begin : g_bad_pres
         $error("present bit must sit above the limit field");
      end
   endgenerate

   logic [ADDR_W-1:0]  sys_base_q;
   logic [ADDR_W-1:0]  proc_base_q;
   logic [LIMIT_W-1:0] proc_limit_q;
   logic               proc_ok_q;

   logic               kind_q;
   logic [ADDR_W-1:0]  off_q;
   logic [ADDR_W-1:0]  ent_q;
   logic [ADDR_W-1:0]  word0_q;
   logic               fault_q;
   logic [ADDR_W-1:0]  lin_q;

   logic               accept;
   logic               pre_fault;
   logic [ADDR_W-1:0]  entry_addr;
   logic               rd_second, cap_word0, cap_word1;

   logic [ADDR_W-1:0]  d_base;
   logic [LIMIT_W-1:0] d_limit;
   logic               d_fault;
   logic [ADDR_W-1:0]  d_result;

   seg_sel_decode #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .LIMIT_W(LIMIT_W)
   ) i_decode (
      .sel        (req_sel),
      .kind       (req_load),
      .sys_base   (sys_base_q),
      .proc_base  (proc_base_q),
      .proc_limit (proc_limit_q),
      .proc_ok    (proc_ok_q),
      .entry_addr (entry_addr),
      .pre_fault  (pre_fault)
   );

   seg_xlate_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .pre_fault (pre_fault),
      .rd_valid  (mem_rd_valid),
      .ready     (req_ready),
      .rd_en     (mem_rd_en),
      .rd_second (rd_second),
      .cap_word0 (cap_word0),
      .cap_word1 (cap_word1),
      .rsp_pulse (rsp_valid)
   );

   seg_desc_eval #(
      .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .PRES_BIT(PRES_BIT)
   ) i_eval (
      .kind      (kind_q),
      .word0     (word0_q),
      .word1     (mem_rd_data),
      .offset    (off_q),
      .seg_base  (d_base),
      .seg_limit (d_limit),
      .fault     (d_fault),
      .result    (d_result)
   );

   assign accept      = req_valid && req_ready;
   assign mem_rd_addr = rd_second ? ent_q + ADDR_W'(WORD_BYTES) : ent_q;
   assign rsp_fault   = fault_q;
   assign rsp_lin     = lin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_base_q <= '0;
      end else if (gtab_wr_en) begin
         sys_base_q <= gtab_wr_base;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= KIND_XLATE;
         off_q   <= '0;
         ent_q   <= '0;
         word0_q <= '0;
         fault_q <= 1'b0;
         lin_q   <= '0;
      end else begin
         if (accept) begin
            kind_q <= req_load;
            off_q  <= req_off;
            ent_q  <= entry_addr;
            if (pre_fault) begin
               fault_q <= 1'b1;
               lin_q   <= '0;
            end
         end
         if (cap_word0) word0_q <= mem_rd_data;
         if (cap_word1) begin
            fault_q <= d_fault;
            lin_q   <= d_result;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         proc_base_q  <= '0;
         proc_limit_q <= '0;
         proc_ok_q    <= 1'b0;
      end else if (cap_word1 && kind_q == KIND_LOAD && !d_fault) begin
         proc_base_q  <= d_base;
         proc_limit_q <= d_limit;
         proc_ok_q    <= 1'b1;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 16,
   parameter int IDX_W  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_load,
   input logic [SEL_W-1:0]  req_sel,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [ADDR_W-1:0] rsp_lin,
   input logic              mem_rd_en
);
   localparam int TI_BIT = SEL_W - IDX_W - 1;

   logic null_sys;
   assign null_sys = !req_load && !req_sel[TI_BIT] && (req_sel[SEL_W-1 -: IDX_W] == '0);

   a_r10_rsp_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en);

   a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_lin == '0));

   a_r6_null_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && null_sys) |=> (rsp_valid && rsp_fault && !mem_rd_en));

endmodule

bind seg_xlate seg_xlate_chk #(
   .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
) i_seg_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_load  (req_load),
   .req_sel   (req_sel),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_lin   (rsp_lin),
   .mem_rd_en (mem_rd_en)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gtab_wr_en = 1'b0;
   logic [31:0] gtab_wr_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_load = 1'b0;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic        rsp_valid, rsp_fault;
   logic [31:0] rsp_lin;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data = '0;
   logic        mem_rd_valid = 1'b0;

   int checks = 0;
   int failures = 0;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n),
      .gtab_wr_en(gtab_wr_en), .gtab_wr_base(gtab_wr_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_load(req_load),
      .req_sel(req_sel), .req_off(req_off),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model with programmable latency
   logic [31:0] mem [0:1023];
   int          lat = 1;
   int          p_cnt = 0;
   logic [31:0] p_addr = '0;
   int          rd_total = 0;
   logic [31:0] rd_log [0:63];

   always @(posedge clk) begin
      mem_rd_valid <= 1'b0;
      if (mem_rd_en) begin
         p_addr <= mem_rd_addr;
         p_cnt  <= lat;
         rd_log[rd_total % 64] <= mem_rd_addr;
         rd_total <= rd_total + 1;
      end else if (p_cnt != 0) begin
         p_cnt <= p_cnt - 1;
         if (p_cnt == 1) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem[p_addr[11:2]];
         end
      end
   end

   function automatic logic [15:0] mk_sel(int idx, bit tbl, int rsv);
      return 16'((idx << 3) | (int'(tbl) << 2) | (rsv & 3));
   endfunction

   task automatic put_desc(int addr, logic [31:0] base, logic [19:0] limit, bit pres);
      mem[addr/4]     = base;
      mem[addr/4 + 1] = {pres, 11'd0, limit};
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   logic        r_fault;
   logic [31:0] r_lin;
   int          r_reads;
   int          r_first;

   task automatic do_req(bit load, logic [15:0] sel, logic [31:0] off);
      int n = 0;
      @(negedge clk);
      while (!req_ready && n < 2000) begin @(negedge clk); n++; end
      req_valid = 1'b1; req_load = load; req_sel = sel; req_off = off;
      r_first = rd_total;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 busy after accept", 32'(req_ready), 32'd0);
      n = 0;
      while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
      if (!rsp_valid) check("R10 response timeout", 32'd0, 32'd1);
      r_fault = rsp_fault;
      r_lin   = rsp_lin;
      r_reads = rd_total - r_first;
   endtask

   task automatic set_gbase(logic [31:0] b);
      @(negedge clk);
      gtab_wr_en = 1'b1; gtab_wr_base = b;
      @(negedge clk);
      gtab_wr_en = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 ready at reset", 32'(req_ready), 32'd1);
      check("R1 rsp_valid at reset", 32'(rsp_valid), 32'd0);
      check("R1 rd_en at reset", 32'(mem_rd_en), 32'd0);
   endtask

   task automatic t_global_basic;
      set_gbase(32'h100);
      do_req(1'b0, mk_sel(1, 0, 0), 32'h123);
      check("R3 fault", 32'(r_fault), 32'd0);
      check("R3 lin", r_lin, 32'h0001_0123);
      check("R3 reads", 32'(r_reads), 32'd2);
      check("R3 addr word0", rd_log[r_first % 64], 32'h108);
      check("R3 addr word1", rd_log[(r_first + 1) % 64], 32'h10C);
   endtask

   task automatic t_reserved;
      do_req(1'b0, mk_sel(1, 0, 3), 32'h123);
      check("R2 rsv bits ignored lin", r_lin, 32'h0001_0123);
      check("R2 rsv bits ignored fault", 32'(r_fault), 32'd0);
   endtask

   task automatic t_limit;
      do_req(1'b0, mk_sel(1, 0, 0), 32'hFFF);
      check("R4 at limit fault", 32'(r_fault), 32'd0);
      check("R4 at limit lin", r_lin, 32'h0001_0FFF);
      do_req(1'b0, mk_sel(1, 0, 0), 32'h1000);
      check("R4 over limit fault", 32'(r_fault), 32'd1);
      check("R5 over limit lin zero", r_lin, 32'd0);
   endtask

   task automatic t_wrap;
      do_req(1'b0, mk_sel(2, 0, 0), 32'h2000);
      check("R3 wrap lin", r_lin, 32'h0000_1000);
      check("R3 wrap fault", 32'(r_fault), 32'd0);
   endtask

   task automatic t_not_present;
      do_req(1'b0, mk_sel(3, 0, 0), 32'h0);
      check("R5 absent fault", 32'(r_fault), 32'd1);
      check("R5 absent lin", r_lin, 32'd0);
      check("R5 absent reads", 32'(r_reads), 32'd2);
   endtask

   task automatic t_null;
      do_req(1'b0, mk_sel(0, 0, 0), 32'h10);
      check("R6 null fault", 32'(r_fault), 32'd1);
      check("R6 null reads", 32'(r_reads), 32'd0);
      do_req(1'b0, mk_sel(0, 0, 3), 32'h10);
      check("R6 null rsv fault", 32'(r_fault), 32'd1);
      do_req(1'b0, mk_sel(0, 1, 0), 32'h10);
      check("R8 no table fault", 32'(r_fault), 32'd1);
      check("R8 no table reads", 32'(r_reads), 32'd0);
   endtask

   task automatic t_local_load;
      do_req(1'b1, mk_sel(4, 0, 0), 32'h0);
      check("R7 load fault", 32'(r_fault), 32'd0);
      check("R7 load lin", r_lin, 32'h800);
      check("R7 load addr", rd_log[r_first % 64], 32'h120);
      do_req(1'b0, mk_sel(0, 1, 0), 32'h10);
      check("R7 local idx0 lin", r_lin, 32'h2000_0010);
      check("R7 local addr", rd_log[r_first % 64], 32'h800);
      check("R7 local addr word1", rd_log[(r_first + 1) % 64], 32'h804);
      do_req(1'b0, mk_sel(1, 1, 0), 32'h11);
      check("R4 local over limit", 32'(r_fault), 32'd1);
      do_req(1'b0, mk_sel(1, 1, 2), 32'h10);
      check("R4 local at limit", r_lin, 32'h3000_0010);
      do_req(1'b0, mk_sel(2, 1, 0), 32'h0);
      check("R5 local absent", 32'(r_fault), 32'd1);
      do_req(1'b0, mk_sel(3, 1, 0), 32'h0);
      check("R8 beyond table fault", 32'(r_fault), 32'd1);
      check("R8 beyond table reads", 32'(r_reads), 32'd0);
   endtask

   task automatic t_bad_load;
      do_req(1'b1, mk_sel(3, 0, 0), 32'h0);
      check("R9 absent load fault", 32'(r_fault), 32'd1);
      do_req(1'b1, mk_sel(4, 1, 0), 32'h0);
      check("R9 tbl1 load fault", 32'(r_fault), 32'd1);
      check("R9 tbl1 load reads", 32'(r_reads), 32'd0);
      do_req(1'b1, mk_sel(0, 0, 0), 32'h0);
      check("R9 idx0 load fault", 32'(r_fault), 32'd1);
      check("R9 idx0 load reads", 32'(r_reads), 32'd0);
      do_req(1'b0, mk_sel(0, 1, 0), 32'h10);
      check("R9 table kept", r_lin, 32'h2000_0010);
   endtask

   task automatic t_reload;
      do_req(1'b1, mk_sel(6, 0, 0), 32'h0);
      check("R7 reload lin", r_lin, 32'h900);
      do_req(1'b0, mk_sel(0, 1, 0), 32'h5);
      check("R7 reload local", r_lin, 32'h4000_0005);
      do_req(1'b0, mk_sel(1, 1, 0), 32'h0);
      check("R8 reload small table", 32'(r_fault), 32'd1);
   endtask

   task automatic t_latency;
      lat = 5;
      do_req(1'b0, mk_sel(1, 0, 0), 32'h44);
      check("R11 slow memory lin", r_lin, 32'h0001_0044);
      check("R11 slow memory reads", 32'(r_reads), 32'd2);
      lat = 1;
   endtask

   task automatic t_gbase;
      set_gbase(32'h800);
      do_req(1'b0, mk_sel(1, 0, 0), 32'h4);
      check("R12 new base addr", rd_log[r_first % 64], 32'h808);
      check("R12 new base lin", r_lin, 32'h3000_0004);
      set_gbase(32'h100);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      put_desc(32'h108, 32'h0001_0000, 20'h00FFF, 1'b1);
      put_desc(32'h110, 32'hFFFF_F000, 20'hFFFFF, 1'b1);
      put_desc(32'h118, 32'h0005_0000, 20'hFFFFF, 1'b0);
      put_desc(32'h120, 32'h0000_0800, 20'h00017, 1'b1);
      put_desc(32'h130, 32'h0000_0900, 20'h00007, 1'b1);
      put_desc(32'h800, 32'h2000_0000, 20'h000FF, 1'b1);
      put_desc(32'h808, 32'h3000_0000, 20'h00010, 1'b1);
      put_desc(32'h810, 32'h6000_0000, 20'h000FF, 1'b0);
      put_desc(32'h900, 32'h4000_0000, 20'hFFFFF, 1'b1);

      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_global_basic;
      t_reserved;
      t_limit;
      t_wrap;
      t_not_present;
      t_null;
      t_local_load;
      t_bad_load;
      t_reload;
      t_latency;
      t_gbase;
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule